// File: doc/BRIEF.md
# Dual-Channel DMA Request/Acknowledge Controller

This block sits between two packet-buffer FIFO ports and an external DMA engine. Each of its two channels raises an active-high request line when its FIFO port can take part in a transfer. It counts one data transfer each time the DMA engine releases the strobe that the channel has chosen as its acknowledge. Each channel has its own direction and mode, its own choice of strobe and its own transaction limit. Software sets these through plain configuration inputs.

In cycle-steal mode a channel asks for one byte or word at a time. It drops its request after every transfer and raises it again for the next one. In burst mode the request stays high until the buffer area assigned to the channel has been moved, or until a transfer-end indication arrives. In the receive direction the channel pulls the shared, active-low transfer-end line on the last transfer of each buffer area. An arriving zero-length packet clears the buffer and closes the run without moving any data. In the transmit direction a transfer-end input from the DMA engine closes the run and can request that a zero-length packet be appended. An optional transaction counter stops the channel after a set number of completed runs. The channel then stays stopped until software clears its done flag.

Top module: `dma_hs_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `dreq`, `done`, `xfer`, `dend_oe`, `zlp_send` and `buf_clr` are all low.
- R2: `dreq[c]` is high only while `cfg_en[c]` is high, `fifo_ready[c]` is high and `done[c]` is low. A channel that is enabled and whose FIFO turns ready raises `dreq[c]` within a few cycles.
- R3: In cycle-steal mode (`cfg_burst[c]`=0) `dreq[c]` falls once after every counted transfer, and then rises again while the channel stays ready.
- R4: In burst mode (`cfg_burst[c]`=1) `dreq[c]` stays high across the transfers of a run. It falls once, when the run closes after `cfg_len[c]` transfers (a length of 0 counts as 1).
- R5: `cfg_stb_sel[c]` picks the acknowledge: 0 is `cs_n`, 1 is `rd_n`, 2 is `wr_n`, 3 is the channel's own `dack_n[c]`. All strobes are active low and pass a two-flop synchronizer. A transfer is counted on the low-to-high edge of the selected strobe only, and each count gives a one-cycle `xfer[c]` pulse. Edges on the other strobes are not counted.
- R6: In the receive direction (`cfg_dir_tx[c]`=0) the last transfer of a run gives exactly one one-cycle pulse on `dend_oe[c]`. No other case drives it.
- R7: In the transmit direction (`cfg_dir_tx[c]`=1) a high-to-low edge on `dend_n_i[c]` during a run closes the run, and `dreq[c]` falls. If `cfg_zlp_app[c]` is 1, exactly one one-cycle `zlp_send[c]` pulse follows. If it is 0, no pulse follows.
- R8: In the receive direction a `zlp_rx[c]` pulse on an enabled channel that is not done gives one one-cycle `buf_clr[c]` pulse and closes the run. No `xfer[c]` pulse and no `dend_oe[c]` pulse result from it.
- R9: With `cfg_tc_en[c]`=1 the channel loads `cfg_tc_limit[c]` at the first run start. `done[c]` rises when that many runs have closed (a limit of 0 counts as 1). `dreq[c]` then stays low.
- R10: `done[c]` stays high until a `done_clr[c]` pulse. After that pulse the channel requests again if it is enabled and ready.
- R11: Each channel's request, transfer count and events are unaffected by traffic on the other channel's own acknowledge strobe.
- R12: A selected-strobe edge is not counted while the channel has no request outstanding, for example while it is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | NCH | Channel enable |
| cfg_burst | input | NCH | 1 = burst mode, 0 = cycle-steal mode |
| cfg_dir_tx | input | NCH | 1 = transmit (DMA writes buffer), 0 = receive (DMA reads buffer) |
| cfg_zlp_app | input | NCH | Append zero-length packet on transfer-end input |
| cfg_tc_en | input | NCH | Enable transaction counter |
| cfg_stb_sel | input | 2*NCH | Acknowledge strobe select, 2 bits per channel |
| cfg_len | input | LEN_W*NCH | Transfers per run (buffer area size) per channel |
| cfg_tc_limit | input | CNT_W*NCH | Runs before done, per channel |
| done_clr | input | NCH | Software clear of the done flag |
| fifo_ready | input | NCH | FIFO port ready (not empty on receive, not full on transmit) |
| zlp_rx | input | NCH | Pulse: zero-length packet arrived |
| cs_n | input | 1 | Chip select strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| dack_n | input | NCH | Per-channel DMA acknowledge, active low |
| dend_n_i | input | NCH | Transfer-end line as seen at the pad, active low |
| dreq | output | NCH | DMA request, active high |
| xfer | output | NCH | Pulse: one transfer counted |
| dend_oe | output | NCH | Pulse: pad pulls transfer-end line low |
| zlp_send | output | NCH | Pulse: append a zero-length packet |
| buf_clr | output | NCH | Pulse: clear the buffer after a zero-length packet |
| done | output | NCH | Sticky transaction-count done flag |

## Verification
A remaining-count register that is off by one shows up at the end of the same run. The `dend_oe` pulse arrives one transfer early or late, and in burst mode the single fall of `dreq` moves with it. A state machine stuck in its request state shows up after the very next counted transfer in cycle-steal mode, because the fall of `dreq` never comes. A wrong strobe decode or edge choice shows up as an `xfer` pulse that is missing or extra within about three cycles of the strobe releasing. A transaction counter that loses count shows up as `done` rising one run early or late. A done flag that clears itself shows up as `dreq` returning without a `done_clr` pulse.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;

    typedef enum logic [1:0] {
        STB_CS  = 2'd0,
        STB_RD  = 2'd1,
        STB_WR  = 2'd2,
        STB_ACK = 2'd3
    } stb_sel_e;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_REQ  = 2'd1,
        CH_GAP  = 2'd2
    } ch_state_e;

    typedef struct packed {
        logic     en;
        logic     burst;
        logic     dir_tx;
        logic     zlp_app;
        logic     tc_en;
        stb_sel_e sel;
    } ch_mode_t;

    typedef struct packed {
        logic xfer;
        logic dend;
        logic zlp_send;
        logic buf_clr;
    } ch_evt_t;

    // Bit order of the per-channel strobe edge vector: cs, rd, wr, own ack.
    localparam int STB_NUM = 4;

    function automatic logic pick_strobe(stb_sel_e sel, logic [STB_NUM-1:0] edges);
        logic hit;
        case (sel)
            STB_CS:  hit = edges[0];
            STB_RD:  hit = edges[1];
            STB_WR:  hit = edges[2];
            default: hit = edges[3];
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/dma_hs_sync.sv
module dma_hs_sync #(
    parameter int W           = 1,
    parameter bit DETECT_RISE = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_n,
    output logic [W-1:0] edge_evt
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '1;
            sync_q <= '1;
            hist_q <= '1;
        end else begin
            meta_q <= pin_n;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    generate
        if (DETECT_RISE) begin : g_rise
            assign edge_evt = sync_q & ~hist_q;
        end else begin : g_fall
            assign edge_evt = ~sync_q & hist_q;
        end
    endgenerate

endmodule

// File: rtl/dma_hs_chan.sv
module dma_hs_chan
    import dma_hs_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  ch_mode_t           mode,
    input  logic [LEN_W-1:0]   len,
    input  logic [CNT_W-1:0]   tc_limit,
    input  logic               fifo_ready,
    input  logic [STB_NUM-1:0] stb_rise,
    input  logic               dend_fall,
    input  logic               zlp_rx,
    input  logic               done_clr,
    output logic               dreq,
    output ch_evt_t            evt,
    output logic               done
);
    ch_state_e        st_q;
    logic [LEN_W-1:0] rem_q;
    logic [CNT_W-1:0] tc_left_q;
    logic             tc_live_q;
    logic             done_q;
    ch_evt_t          evt_q;

    logic             stb_hit;
    logic             xfer_evt;
    logic             last_evt;
    logic             dend_end;
    logic             zlp_end;
    logic             run_end;
    logic [LEN_W-1:0] len_eff;

    always_comb begin
        stb_hit  = pick_strobe(mode.sel, stb_rise);
        xfer_evt = (st_q == CH_REQ) && stb_hit;
        last_evt = xfer_evt && (rem_q == LEN_W'(1));
        dend_end = mode.dir_tx && dend_fall && (rem_q != '0);
        zlp_end  = !mode.dir_tx && zlp_rx && mode.en && !done_q;
        run_end  = last_evt || dend_end || zlp_end;
        len_eff  = (len == '0) ? LEN_W'(1) : len;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= CH_IDLE;
            rem_q     <= '0;
            tc_left_q <= '0;
            tc_live_q <= 1'b0;
            done_q    <= 1'b0;
            evt_q     <= '0;
        end else begin
            evt_q.xfer     <= xfer_evt;
            evt_q.dend     <= last_evt && !mode.dir_tx;
            evt_q.zlp_send <= dend_end && mode.zlp_app;
            evt_q.buf_clr  <= zlp_end;

            if (done_clr) begin
                done_q    <= 1'b0;
                tc_live_q <= 1'b0;
            end

            if (run_end) begin
                rem_q <= '0;
                st_q  <= CH_GAP;
                if (mode.tc_en && tc_live_q) begin
                    tc_left_q <= tc_left_q - CNT_W'(1);
                    if (tc_left_q <= CNT_W'(1)) begin
                        done_q    <= 1'b1;
                        tc_live_q <= 1'b0;
                    end
                end
            end else begin
                case (st_q)
                    CH_IDLE: begin
                        if (!mode.en) begin
                            rem_q <= '0;
                        end else if (!done_q && fifo_ready) begin
                            st_q <= CH_REQ;
                            if (rem_q == '0) begin
                                rem_q <= len_eff;
                            end
                            if (mode.tc_en && !tc_live_q) begin
                                tc_left_q <= tc_limit;
                                tc_live_q <= 1'b1;
                            end
                        end
                    end
                    CH_REQ: begin
                        if (!mode.en) begin
                            st_q <= CH_IDLE;
                        end else if (xfer_evt) begin
                            rem_q <= rem_q - LEN_W'(1);
                            if (!mode.burst) begin
                                st_q <= CH_GAP;
                            end
                        end
                    end
                    default: st_q <= CH_IDLE;
                endcase
            end
        end
    end

    assign dreq = (st_q == CH_REQ) && fifo_ready && mode.en;
    assign evt  = evt_q;
    assign done = done_q;

endmodule

// File: rtl/dma_hs_ctrl.sv
module dma_hs_ctrl
    import dma_hs_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int LEN_W = 8,
    parameter int CNT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NCH-1:0]       cfg_en,
    input  logic [NCH-1:0]       cfg_burst,
    input  logic [NCH-1:0]       cfg_dir_tx,
    input  logic [NCH-1:0]       cfg_zlp_app,
    input  logic [NCH-1:0]       cfg_tc_en,
    input  logic [2*NCH-1:0]     cfg_stb_sel,
    input  logic [LEN_W*NCH-1:0] cfg_len,
    input  logic [CNT_W*NCH-1:0] cfg_tc_limit,
    input  logic [NCH-1:0]       done_clr,
    input  logic [NCH-1:0]       fifo_ready,
    input  logic [NCH-1:0]       zlp_rx,
    input  logic                 cs_n,
    input  logic                 rd_n,
    input  logic                 wr_n,
    input  logic [NCH-1:0]       dack_n,
    input  logic [NCH-1:0]       dend_n_i,
    output logic [NCH-1:0]       dreq,
    output logic [NCH-1:0]       xfer,
    output logic [NCH-1:0]       dend_oe,
    output logic [NCH-1:0]       zlp_send,
    output logic [NCH-1:0]       buf_clr,
    output logic [NCH-1:0]       done
);
    localparam int SHARED_W = 3;
    localparam int STB_W    = SHARED_W + NCH;

    logic [STB_W-1:0] stb_rise;
    logic [NCH-1:0]   dend_fall;

    dma_hs_sync #(.W(STB_W), .DETECT_RISE(1'b1)) i_stb_sync (
        .clk      (clk),
        .rst      (rst),
        .pin_n    ({dack_n, wr_n, rd_n, cs_n}),
        .edge_evt (stb_rise)
    );

    dma_hs_sync #(.W(NCH), .DETECT_RISE(1'b0)) i_dend_sync (
        .clk      (clk),
        .rst      (rst),
        .pin_n    (dend_n_i),
        .edge_evt (dend_fall)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        ch_mode_t           mode;
        ch_evt_t            evt;
        logic [STB_NUM-1:0] ch_rise;

        assign mode.en      = cfg_en[c];
        assign mode.burst   = cfg_burst[c];
        assign mode.dir_tx  = cfg_dir_tx[c];
        assign mode.zlp_app = cfg_zlp_app[c];
        assign mode.tc_en   = cfg_tc_en[c];
        assign mode.sel     = stb_sel_e'(cfg_stb_sel[2*c +: 2]);
        assign ch_rise      = {stb_rise[SHARED_W+c], stb_rise[SHARED_W-1:0]};

        dma_hs_chan #(.LEN_W(LEN_W), .CNT_W(CNT_W)) i_chan (
            .clk        (clk),
            .rst        (rst),
            .mode       (mode),
            .len        (cfg_len[LEN_W*c +: LEN_W]),
            .tc_limit   (cfg_tc_limit[CNT_W*c +: CNT_W]),
            .fifo_ready (fifo_ready[c]),
            .stb_rise   (ch_rise),
            .dend_fall  (dend_fall[c]),
            .zlp_rx     (zlp_rx[c]),
            .done_clr   (done_clr[c]),
            .dreq       (dreq[c]),
            .evt        (evt),
            .done       (done[c])
        );

        assign xfer[c]     = evt.xfer;
        assign dend_oe[c]  = evt.dend;
        assign zlp_send[c] = evt.zlp_send;
        assign buf_clr[c]  = evt.buf_clr;
    end

endmodule

// File: rtl/dma_hs_chk.sv
module dma_hs_chk #(
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] cfg_en,
    input logic [NCH-1:0] cfg_dir_tx,
    input logic [NCH-1:0] cfg_zlp_app,
    input logic [NCH-1:0] cfg_tc_en,
    input logic [NCH-1:0] done_clr,
    input logic [NCH-1:0] fifo_ready,
    input logic [NCH-1:0] zlp_rx,
    input logic [NCH-1:0] dreq,
    input logic [NCH-1:0] dend_oe,
    input logic [NCH-1:0] zlp_send,
    input logic [NCH-1:0] buf_clr,
    input logic [NCH-1:0] done
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (dreq == '0 && done == '0 && dend_oe == '0));

    for (genvar c = 0; c < NCH; c++) begin : g_a
        // R2
        dreq_gate_chk: assert property (@(posedge clk) disable iff (rst)
            dreq[c] |-> (fifo_ready[c] && cfg_en[c] && !done[c]));
        // R6
        dend_pulse_chk: assert property (@(posedge clk) disable iff (rst)
            dend_oe[c] |=> !dend_oe[c]);
        // R6
        dend_dir_chk: assert property (@(posedge clk) disable iff (rst)
            dend_oe[c] |-> !$past(cfg_dir_tx[c]));
        // R7
        zlp_src_chk: assert property (@(posedge clk) disable iff (rst)
            zlp_send[c] |-> $past(cfg_zlp_app[c] && cfg_dir_tx[c]));
        // R8
        clr_src_chk: assert property (@(posedge clk) disable iff (rst)
            buf_clr[c] |-> ($past(zlp_rx[c]) && !$past(cfg_dir_tx[c])));
        // R9
        done_rise_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(done[c]) |-> $past(cfg_tc_en[c]));
        // R10
        done_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (done[c] && !done_clr[c]) |=> done[c]);
    end

endmodule

bind dma_hs_ctrl dma_hs_chk #(.NCH(NCH)) i_dma_hs_chk (.*);

// File: tb/test_dma_hs_ctrl.sv
`timescale 1ns/1ps
module test_dma_hs_ctrl;
    localparam int NCH   = 2;
    localparam int LEN_W = 8;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                 rst;
    logic [NCH-1:0]       cfg_en, cfg_burst, cfg_dir_tx, cfg_zlp_app, cfg_tc_en;
    logic [2*NCH-1:0]     cfg_stb_sel;
    logic [LEN_W*NCH-1:0] cfg_len;
    logic [CNT_W*NCH-1:0] cfg_tc_limit;
    logic [NCH-1:0]       done_clr, fifo_ready, zlp_rx, dack_n, dend_n_i;
    logic                 cs_n, rd_n, wr_n;
    logic [NCH-1:0]       dreq, xfer, dend_oe, zlp_send, buf_clr, done;

    dma_hs_ctrl #(.NCH(NCH), .LEN_W(LEN_W), .CNT_W(CNT_W)) i_dma_hs_ctrl (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_burst(cfg_burst),
        .cfg_dir_tx(cfg_dir_tx), .cfg_zlp_app(cfg_zlp_app), .cfg_tc_en(cfg_tc_en),
        .cfg_stb_sel(cfg_stb_sel), .cfg_len(cfg_len), .cfg_tc_limit(cfg_tc_limit),
        .done_clr(done_clr), .fifo_ready(fifo_ready), .zlp_rx(zlp_rx),
        .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .dack_n(dack_n), .dend_n_i(dend_n_i),
        .dreq(dreq), .xfer(xfer), .dend_oe(dend_oe), .zlp_send(zlp_send),
        .buf_clr(buf_clr), .done(done)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int xfer_cnt [NCH];
    int dend_cnt [NCH];
    int zlp_cnt  [NCH];
    int clr_cnt  [NCH];
    int fall_cnt [NCH];
    int b_xfer [NCH];
    int b_dend [NCH];
    int b_zlp  [NCH];
    int b_clr  [NCH];
    int b_fall [NCH];
    logic [NCH-1:0] dreq_prev;

    always @(negedge clk) begin
        if (rst) begin
            for (int c = 0; c < NCH; c++) begin
                xfer_cnt[c] = 0; dend_cnt[c] = 0; zlp_cnt[c] = 0;
                clr_cnt[c] = 0; fall_cnt[c] = 0;
            end
            dreq_prev = '0;
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (xfer[c])     xfer_cnt[c]++;
                if (dend_oe[c])  dend_cnt[c]++;
                if (zlp_send[c]) zlp_cnt[c]++;
                if (buf_clr[c])  clr_cnt[c]++;
                if (dreq_prev[c] && !dreq[c]) fall_cnt[c]++;
            end
            dreq_prev = dreq;
        end
    end

    function automatic int exp_falls(bit burst, int len);
        return burst ? 1 : len;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic snap();
        for (int c = 0; c < NCH; c++) begin
            b_xfer[c] = xfer_cnt[c]; b_dend[c] = dend_cnt[c]; b_zlp[c] = zlp_cnt[c];
            b_clr[c] = clr_cnt[c]; b_fall[c] = fall_cnt[c];
        end
    endtask

    task automatic set_ch(int c, bit en, bit burst, bit tx, bit zapp, bit tcen,
                          int sel, int len, int lim);
        cfg_en[c]      = en;
        cfg_burst[c]   = burst;
        cfg_dir_tx[c]  = tx;
        cfg_zlp_app[c] = zapp;
        cfg_tc_en[c]   = tcen;
        cfg_stb_sel[2*c +: 2]         = sel[1:0];
        cfg_len[LEN_W*c +: LEN_W]     = len[LEN_W-1:0];
        cfg_tc_limit[CNT_W*c +: CNT_W] = lim[CNT_W-1:0];
    endtask

    task automatic pulse_stb(int c, int sel);
        case (sel)
            0: cs_n = 1'b0;
            1: rd_n = 1'b0;
            2: wr_n = 1'b0;
            default: dack_n[c] = 1'b0;
        endcase
        tick(2);
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; dack_n = '1;
        tick(4);
    endtask

    task automatic wait_dreq(int c, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 50; i++) begin
            if (dreq[c]) begin
                ok = 1'b1;
                break;
            end
            tick(1);
        end
    endtask

    task automatic do_xfers(int c, int sel, int n, string req);
        bit ok;
        for (int k = 0; k < n; k++) begin
            wait_dreq(c, ok);
            if (!ok) chk({req, " dreq before transfer"}, 0, 1);
            pulse_stb(c, sel);
        end
    endtask

    task automatic stop_ch(int c);
        cfg_en[c] = 1'b0;
        tick(3);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        bit ok;
        rst = 1'b1;
        cfg_en = '0; cfg_burst = '0; cfg_dir_tx = '0; cfg_zlp_app = '0; cfg_tc_en = '0;
        cfg_stb_sel = '0; cfg_len = '0; cfg_tc_limit = '0;
        done_clr = '0; fifo_ready = '0; zlp_rx = '0;
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; dack_n = '1; dend_n_i = '1;
        tick(4);
        // R1: quiet outputs during reset
        chk("R1 dreq in reset", int'(dreq), 0);
        chk("R1 done in reset", int'(done), 0);
        rst = 1'b0;
        tick(1);
        chk("R1 outputs after reset", int'({dreq, xfer, dend_oe, zlp_send, buf_clr, done}), 0);

        // R2: no request while FIFO not ready
        set_ch(0, 1, 0, 0, 0, 0, 3, 3, 0);
        tick(10);
        chk("R2 dreq with fifo not ready", int'(dreq[0]), 0);
        fifo_ready = '1;
        wait_dreq(0, ok);
        chk("R2 dreq once ready", int'(ok), 1);

        // R3 and R6: cycle-steal receive run of 3
        stop_ch(0);
        set_ch(0, 1, 0, 0, 0, 0, 3, 3, 0);
        snap();
        do_xfers(0, 3, 3, "R3");
        chk("R3 transfers counted", xfer_cnt[0] - b_xfer[0], 3);
        chk("R3 dreq falls per transfer", fall_cnt[0] - b_fall[0], exp_falls(0, 3));
        chk("R6 dend pulses on last transfer", dend_cnt[0] - b_dend[0], 1);
        wait_dreq(0, ok);
        chk("R3 dreq raised again", int'(ok), 1);

        // R4: burst run of 4
        stop_ch(0);
        set_ch(0, 1, 1, 0, 0, 0, 3, 4, 0);
        snap();
        do_xfers(0, 3, 2, "R4");
        chk("R4 dreq held mid-run", int'(dreq[0]), 1);
        chk("R4 no fall mid-run", fall_cnt[0] - b_fall[0], 0);
        chk("R6 no dend mid-run", dend_cnt[0] - b_dend[0], 0);
        do_xfers(0, 3, 2, "R4");
        chk("R4 transfers counted", xfer_cnt[0] - b_xfer[0], 4);
        chk("R4 single fall at run end", fall_cnt[0] - b_fall[0], exp_falls(1, 4));
        chk("R6 dend at burst end", dend_cnt[0] - b_dend[0], 1);

        // R5: strobe select, only the chosen strobe counts
        for (int sel = 0; sel < 4; sel++) begin
            stop_ch(0);
            set_ch(0, 1, 0, 0, 0, 0, sel, 100, 0);
            wait_dreq(0, ok);
            snap();
            for (int o = 0; o < 4; o++) begin
                if (o != sel) pulse_stb(0, o);
            end
            chk("R5 other strobes ignored", xfer_cnt[0] - b_xfer[0], 0);
            pulse_stb(0, sel);
            chk("R5 selected strobe counted", xfer_cnt[0] - b_xfer[0], 1);
        end

        // R12: disabled channel ignores its strobe
        stop_ch(0);
        snap();
        pulse_stb(0, 3);
        chk("R12 strobe ignored when idle", xfer_cnt[0] - b_xfer[0], 0);
        chk("R12 no dreq when disabled", int'(dreq[0]), 0);

        // R7: transmit run closed by transfer-end input, with append
        set_ch(0, 1, 1, 1, 1, 0, 3, 8, 0);
        snap();
        do_xfers(0, 3, 2, "R7");
        dend_n_i[0] = 1'b0;
        tick(2);
        dend_n_i[0] = 1'b1;
        tick(4);
        chk("R7 zlp appended", zlp_cnt[0] - b_zlp[0], 1);
        chk("R7 dreq fell at transfer end", fall_cnt[0] - b_fall[0], 1);
        chk("R6 no dend drive in transmit", dend_cnt[0] - b_dend[0], 0);
        stop_ch(0);
        set_ch(0, 1, 1, 1, 0, 0, 3, 8, 0);
        snap();
        do_xfers(0, 3, 1, "R7");
        dend_n_i[0] = 1'b0;
        tick(2);
        dend_n_i[0] = 1'b1;
        tick(4);
        chk("R7 no zlp when append off", zlp_cnt[0] - b_zlp[0], 0);
        chk("R7 run closed without append", fall_cnt[0] - b_fall[0], 1);

        // R8: zero-length packet received
        stop_ch(0);
        set_ch(0, 1, 0, 0, 0, 0, 3, 4, 0);
        wait_dreq(0, ok);
        snap();
        zlp_rx[0] = 1'b1;
        tick(1);
        zlp_rx[0] = 1'b0;
        tick(4);
        chk("R8 buffer clear pulse", clr_cnt[0] - b_clr[0], 1);
        chk("R8 no transfer", xfer_cnt[0] - b_xfer[0], 0);
        chk("R8 run ended", fall_cnt[0] - b_fall[0], 1);
        chk("R8 no dend", dend_cnt[0] - b_dend[0], 0);

        // R9 and R10: transaction counter
        stop_ch(0);
        set_ch(0, 1, 0, 0, 0, 1, 3, 1, 2);
        snap();
        do_xfers(0, 3, 1, "R9");
        chk("R9 not done after one run", int'(done[0]), 0);
        do_xfers(0, 3, 1, "R9");
        chk("R9 done after limit", int'(done[0]), 1);
        tick(10);
        chk("R9 no dreq while done", int'(dreq[0]), 0);
        pulse_stb(0, 3);
        chk("R10 done is sticky", int'(done[0]), 1);
        chk("R9 strobe ignored while done", xfer_cnt[0] - b_xfer[0], 2);
        done_clr[0] = 1'b1;
        tick(1);
        done_clr[0] = 1'b0;
        wait_dreq(0, ok);
        chk("R10 restart after clear", int'(ok), 1);
        chk("R10 done cleared", int'(done[0]), 0);

        // R11: channels are independent
        stop_ch(0);
        set_ch(0, 1, 1, 0, 0, 0, 3, 50, 0);
        set_ch(1, 1, 0, 0, 0, 0, 3, 50, 0);
        wait_dreq(1, ok);
        snap();
        do_xfers(0, 3, 3, "R11");
        chk("R11 ch0 transfers", xfer_cnt[0] - b_xfer[0], 3);
        chk("R11 ch1 untouched", xfer_cnt[1] - b_xfer[1], 0);
        chk("R11 ch1 dreq held", int'(dreq[1]), 1);
        chk("R11 ch1 no fall", fall_cnt[1] - b_fall[1], 0);
        stop_ch(0);
        stop_ch(1);

        // R3/R4/R5/R6: constrained random runs on channel 1
        void'($urandom(32'd20240611));
        for (int it = 0; it < 24; it++) begin
            bit burst;
            int len;
            int sel;
            burst = 1'($urandom % 2);
            len   = 1 + int'($urandom % 5);
            sel   = int'($urandom % 4);
            set_ch(1, 1, burst, 0, 0, 0, sel, len, 0);
            snap();
            do_xfers(1, sel, len, "R5");
            chk("R5 random transfers", xfer_cnt[1] - b_xfer[1], len);
            chk("R6 random dend", dend_cnt[1] - b_dend[1], 1);
            chk(burst ? "R4 random falls" : "R3 random falls",
                fall_cnt[1] - b_fall[1], exp_falls(burst, len));
            stop_ch(1);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule